// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block holds instructions that have been issued to one functional unit but cannot start yet. Each instruction arrives with an opcode, the tag its own result will carry, and two source fields. A source field holds either a value or the tag of the producer that will compute it. A tag of zero means the value is already present. Producer identifiers therefore start at 1.

The station watches a single result broadcast bus. On every cycle, any pending source whose tag equals the broadcast tag takes the broadcast value. An entry whose two sources are both values is ready. When the functional unit is not busy, the oldest ready entry starts on it through a one-cycle start strobe. That entry is freed in the same cycle.

Entries may start out of program order. The station stalls issue only when every entry is occupied. Issue logic drives the issue port and holds the instruction until the full flag is low.

Top module: `reservation_station`

## Requirements
- R1: After reset `rs_full` is 0 and `fu_start` is 0.
- R2: A source tag of 0 means the accompanying value is valid. An instruction issued with both source tags 0 into an idle station appears on `fu_start` with its fields in the cycle after the issue edge.
- R3: A broadcast (`bc_valid` high) whose `bc_tag` equals a pending source tag replaces that source with `bc_val`. A broadcast with a tag that no pending source names has no effect on any entry.
- R4: A broadcast in the same cycle as an issue whose source tag equals `bc_tag` is captured at issue, and the instruction then dispatches with `bc_val` as that operand.
- R5: An entry never dispatches while either source still holds a nonzero tag.
- R6: While `fu_busy` is high, `fu_start` stays low. A ready entry waits and dispatches once `fu_busy` falls.
- R7: `rs_full` is high exactly when all DEPTH entries are occupied. An issue presented while `rs_full` is high creates no entry and is never dispatched.
- R8: A later instruction whose operands are ready dispatches while an earlier instruction is still waiting on a tag.
- R9: When several entries are ready, the one issued earliest dispatches first, whatever slot it occupies.
- R10: An entry is freed in the cycle it dispatches. Every accepted instruction dispatches exactly once, with the operand values it was issued or woken with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_opcode | input | OP_W | Opcode of the issued instruction |
| iss_dest | input | TAG_W | Tag of the issued instruction's result |
| iss_a_tag | input | TAG_W | Source A producer tag, 0 when the value is valid |
| iss_a_val | input | DW | Source A value |
| iss_b_tag | input | TAG_W | Source B producer tag, 0 when the value is valid |
| iss_b_val | input | DW | Source B value |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DW | Broadcast result value |
| rs_full | output | 1 | All entries occupied; issue must stall |
| fu_busy | input | 1 | Functional unit cannot accept a start |
| fu_start | output | 1 | Dispatch strobe to the functional unit |
| fu_opcode | output | OP_W | Opcode of the dispatched entry |
| fu_dest | output | TAG_W | Result tag of the dispatched entry |
| fu_a | output | DW | Operand A of the dispatched entry |
| fu_b | output | DW | Operand B of the dispatched entry |

## Verification
The bench goes after several corner cases. The first is a broadcast that coincides with the issue naming its tag; a design that checks only stored entries loses that wakeup, and the instruction hangs. A broadcast carrying an unrelated tag must not wake an entry early. A young ready entry placed in a lower slot than older ready entries exposes a design that picks by slot index instead of by age, which shows up as a wrong dispatch order. Issuing into a full station and draining it catches a design that overwrites an entry or later dispatches the rejected instruction. A scoreboard keyed by result tag flags any lost, duplicated or corrupted dispatch.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Tag value that marks a source as holding a valid value.
  localparam int unsigned TAG_HAVE_VALUE = 0;

  // A pending source wakes when the bus carries its producer's tag.
  function automatic logic tag_wakes(input logic [31:0] pend_tag,
                                     input logic        bus_valid,
                                     input logic [31:0] bus_tag);
    return bus_valid && (pend_tag != 32'(TAG_HAVE_VALUE)) && (pend_tag == bus_tag);
  endfunction

  // An entry can start once both sources hold values.
  function automatic logic srcs_present(input logic [31:0] tag_a,
                                        input logic [31:0] tag_b);
    return (tag_a == 32'(TAG_HAVE_VALUE)) && (tag_b == 32'(TAG_HAVE_VALUE));
  endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int OP_W  = 4,
  parameter int TAG_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             release_now,
  input  logic [OP_W-1:0]  in_op,
  input  logic [TAG_W-1:0] in_dest,
  input  logic [TAG_W-1:0] in_a_tag,
  input  logic [DW-1:0]    in_a_val,
  input  logic [TAG_W-1:0] in_b_tag,
  input  logic [DW-1:0]    in_b_val,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  input  logic [DW-1:0]    bc_val,
  output logic             occ,
  output logic             ready,
  output logic [OP_W-1:0]  op,
  output logic [TAG_W-1:0] dest,
  output logic [DW-1:0]    a_val,
  output logic [DW-1:0]    b_val
);
  import rs_pkg::*;

  logic [TAG_W-1:0] a_tag, b_tag;

  // Wakeup events, named for visibility.
  logic wake_in_a, wake_in_b, wake_a, wake_b;
  assign wake_in_a = tag_wakes(32'(in_a_tag), bc_valid, 32'(bc_tag));
  assign wake_in_b = tag_wakes(32'(in_b_tag), bc_valid, 32'(bc_tag));
  assign wake_a    = occ && tag_wakes(32'(a_tag), bc_valid, 32'(bc_tag));
  assign wake_b    = occ && tag_wakes(32'(b_tag), bc_valid, 32'(bc_tag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ   <= 1'b0;
      op    <= '0;
      dest  <= '0;
      a_tag <= '0;
      b_tag <= '0;
      a_val <= '0;
      b_val <= '0;
    end else if (alloc) begin
      occ   <= 1'b1;
      op    <= in_op;
      dest  <= in_dest;
      a_tag <= wake_in_a ? '0 : in_a_tag;
      a_val <= wake_in_a ? bc_val : in_a_val;
      b_tag <= wake_in_b ? '0 : in_b_tag;
      b_val <= wake_in_b ? bc_val : in_b_val;
    end else begin
      if (release_now) occ <= 1'b0;
      if (wake_a) begin
        a_tag <= '0;
        a_val <= bc_val;
      end
      if (wake_b) begin
        b_tag <= '0;
        b_val <= bc_val;
      end
    end
  end

  assign ready = occ && srcs_present(32'(a_tag), 32'(b_tag));

endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] occ,
  input  logic [N-1:0] ready,
  output logic [N-1:0] pick_oh
);
  // ahead[i][j] = 1: entry j was allocated before entry i.
  logic [N-1:0] ahead [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)           ahead[i] <= '0;
      else if (alloc_oh[i]) ahead[i] <= occ;
      else                  ahead[i] <= ahead[i] & ~alloc_oh;
    end
    assign pick_oh[i] = ready[i] && !(|(ahead[i] & ready));
  end

endmodule

// File: rtl/rs_free_find.sv
module rs_free_find #(
  parameter int N = 4
) (
  input  logic [N-1:0] occ,
  output logic [N-1:0] free_oh
);
  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (!occ[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/reservation_station.sv
module reservation_station #(
  parameter int DEPTH = 4,
  parameter int OP_W  = 4,
  parameter int TAG_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [OP_W-1:0]  iss_opcode,
  input  logic [TAG_W-1:0] iss_dest,
  input  logic [TAG_W-1:0] iss_a_tag,
  input  logic [DW-1:0]    iss_a_val,
  input  logic [TAG_W-1:0] iss_b_tag,
  input  logic [DW-1:0]    iss_b_val,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  input  logic [DW-1:0]    bc_val,
  output logic             rs_full,
  input  logic             fu_busy,
  output logic             fu_start,
  output logic [OP_W-1:0]  fu_opcode,
  output logic [TAG_W-1:0] fu_dest,
  output logic [DW-1:0]    fu_a,
  output logic [DW-1:0]    fu_b
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] occ, ready, free_oh, alloc_oh, pick_oh, release_oh;
  logic             iss_take;
  logic [IDX_W-1:0] pick_idx;

  logic [OP_W-1:0]  s_op   [DEPTH];
  logic [TAG_W-1:0] s_dest [DEPTH];
  logic [DW-1:0]    s_a    [DEPTH];
  logic [DW-1:0]    s_b    [DEPTH];

  assign rs_full    = &occ;
  assign iss_take   = iss_valid && !rs_full;
  assign alloc_oh   = free_oh & {DEPTH{iss_take}};
  assign fu_start   = (|pick_oh) && !fu_busy;
  assign release_oh = pick_oh & {DEPTH{fu_start}};

  rs_free_find #(.N(DEPTH)) u_free (
    .occ     (occ),
    .free_oh (free_oh)
  );

  rs_age_pick #(.N(DEPTH)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_oh (alloc_oh),
    .occ      (occ),
    .ready    (ready),
    .pick_oh  (pick_oh)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DW(DW)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc       (alloc_oh[i]),
      .release_now (release_oh[i]),
      .in_op       (iss_opcode),
      .in_dest     (iss_dest),
      .in_a_tag    (iss_a_tag),
      .in_a_val    (iss_a_val),
      .in_b_tag    (iss_b_tag),
      .in_b_val    (iss_b_val),
      .bc_valid    (bc_valid),
      .bc_tag      (bc_tag),
      .bc_val      (bc_val),
      .occ         (occ[i]),
      .ready       (ready[i]),
      .op          (s_op[i]),
      .dest        (s_dest[i]),
      .a_val       (s_a[i]),
      .b_val       (s_b[i])
    );
  end

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick_oh[i]) pick_idx = IDX_W'(i);
    end
  end

  assign fu_opcode = s_op[pick_idx];
  assign fu_dest   = s_dest[pick_idx];
  assign fu_a      = s_a[pick_idx];
  assign fu_b      = s_b[pick_idx];

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             rs_full,
  input logic             fu_busy,
  input logic             fu_start,
  input logic [DEPTH-1:0] occ,
  input logic [DEPTH-1:0] pick_oh,
  input logic [IDX_W-1:0] pick_idx
);
  // R6: no start while the unit is busy
  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fu_busy |-> !fu_start);

  // R9: the age selector names at most one entry
  p_single_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));

  // R10: the dispatched slot is empty on the next cycle
  p_freed_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fu_start |=> !occ[$past(pick_idx)]);

  // R7: a full station without a dispatch keeps its occupancy
  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_full && !fu_start) |=> ($countones(occ) == $past($countones(occ))));

  // R7: an accepted issue without a dispatch adds one entry
  p_issue_adds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !rs_full && !fu_start) |=>
      ($countones(occ) == $past($countones(occ)) + 1));

endmodule

bind reservation_station rs_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .rs_full   (rs_full),
  .fu_busy   (fu_busy),
  .fu_start  (fu_start),
  .occ       (occ),
  .pick_oh   (pick_oh),
  .pick_idx  (pick_idx)
);

// File: tb/tb_reservation_station.sv
`timescale 1ns/1ps
module tb_reservation_station;
  localparam int DEPTH = 4, OP_W = 4, TAG_W = 4, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [OP_W-1:0]  iss_opcode = '0;
  logic [TAG_W-1:0] iss_dest = '0, iss_a_tag = '0, iss_b_tag = '0;
  logic [DW-1:0]    iss_a_val = '0, iss_b_val = '0;
  logic bc_valid = 1'b0;
  logic [TAG_W-1:0] bc_tag = '0;
  logic [DW-1:0]    bc_val = '0;
  logic rs_full, fu_busy = 1'b0, fu_start;
  logic [OP_W-1:0]  fu_opcode;
  logic [TAG_W-1:0] fu_dest;
  logic [DW-1:0]    fu_a, fu_b;

  always #10 clk = ~clk;  // 50 MHz

  reservation_station #(.DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DW(DW)) dut (.*);

  typedef struct { logic [OP_W-1:0] op; logic [TAG_W-1:0] dest; logic [DW-1:0] a, b; } exp_t;
  exp_t exp_q[$];
  logic [TAG_W-1:0] log_q[$];
  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: presents one issue for one cycle, optionally with a broadcast.
  task automatic issue(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dest,
                       input logic [TAG_W-1:0] at, input logic [DW-1:0] av,
                       input logic [TAG_W-1:0] bt, input logic [DW-1:0] bv,
                       input logic [DW-1:0] ea, input logic [DW-1:0] eb,
                       input bit expect_it, input bit with_bc = 0,
                       input logic [TAG_W-1:0] bct = '0, input logic [DW-1:0] bcv = '0);
    exp_t e;
    @(negedge clk);
    iss_valid = 1'b1; iss_opcode = op; iss_dest = dest;
    iss_a_tag = at; iss_a_val = av; iss_b_tag = bt; iss_b_val = bv;
    if (with_bc) begin bc_valid = 1'b1; bc_tag = bct; bc_val = bcv; end
    if (expect_it) begin
      e.op = op; e.dest = dest; e.a = ea; e.b = eb;
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    iss_valid = 1'b0; bc_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic [DW-1:0] v);
    @(negedge clk);
    bc_valid = 1'b1; bc_tag = t; bc_val = v;
    @(posedge clk); #1;
    bc_valid = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk); #8;
  endtask

  // Monitor: scoreboard keyed by result tag.
  initial begin
    forever begin
      @(negedge clk); #8;
      if (rst_n && fu_start) begin
        int hit;
        hit = -1;
        foreach (exp_q[k]) if (hit < 0 && exp_q[k].dest == fu_dest) hit = k;
        check(hit >= 0, "R10 unexpected dispatch", fu_dest, 0);
        if (hit >= 0) begin
          check(exp_q[hit].op == fu_opcode, "R10 opcode", fu_opcode, exp_q[hit].op);
          check(exp_q[hit].a == fu_a, "R10 operand A", fu_a, exp_q[hit].a);
          check(exp_q[hit].b == fu_b, "R10 operand B", fu_b, exp_q[hit].b);
          exp_q.delete(hit);
        end
        log_q.push_back(fu_dest);
      end
    end
  end

  initial begin
    fork
      begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        sample();
        check(rs_full == 0, "R1 rs_full after reset", rs_full, 0);
        check(fu_start == 0, "R1 fu_start after reset", fu_start, 0);

        // R2: both operands valid at issue
        issue(4'h1, 4'd1, 0, 16'h1111, 0, 16'h2222, 16'h1111, 16'h2222, 1);
        sample();
        check(fu_start && fu_dest == 1, "R2 ready issue dispatches next cycle", fu_dest, 1);

        // R5 / R3: wait on tag 7
        issue(4'h2, 4'd2, 4'd7, 16'h0, 0, 16'h0B0B, 16'h0055, 16'h0B0B, 1);
        for (int i = 0; i < 3; i++) begin
          sample();
          check(!fu_start, "R5 no dispatch with pending tag", fu_start, 0);
        end
        bcast(4'd9, 16'hDEAD);
        sample();
        check(!fu_start, "R3 unrelated broadcast ignored", fu_start, 0);
        bcast(4'd7, 16'h0055);
        sample();
        check(fu_start && fu_a == 16'h0055, "R3 woken operand dispatched", fu_a, 16'h0055);

        // R4: broadcast in the issue cycle
        issue(4'h3, 4'd3, 4'd5, 16'h0, 0, 16'h0003, 16'h002A, 16'h0003, 1, 1, 4'd5, 16'h002A);
        sample();
        check(fu_start && fu_a == 16'h002A, "R4 same-cycle wakeup captured", fu_a, 16'h002A);

        // R6: busy unit
        @(negedge clk); fu_busy = 1'b1;
        issue(4'h4, 4'd4, 0, 16'h0444, 0, 16'h0004, 16'h0444, 16'h0004, 1);
        for (int i = 0; i < 3; i++) begin
          sample();
          check(!fu_start, "R6 held while busy", fu_start, 0);
        end
        @(negedge clk); fu_busy = 1'b0; #8;
        check(fu_start && fu_dest == 4, "R6 dispatch when busy drops", fu_dest, 4);

        // R8: younger independent instruction overtakes
        issue(4'h5, 4'd5, 4'd11, 16'h0, 0, 16'h0005, 16'h0B11, 16'h0005, 1);
        issue(4'h6, 4'd6, 0, 16'h0666, 0, 16'h0006, 16'h0666, 16'h0006, 1);
        sample();
        check(fu_start && fu_dest == 6, "R8 later ready instruction dispatches first", fu_dest, 6);
        bcast(4'd11, 16'h0B11);
        sample();
        check(fu_start && fu_dest == 5, "R8 waiting instruction dispatches after wakeup", fu_dest, 5);

        // R9: oldest ready first, regardless of slot
        @(negedge clk); fu_busy = 1'b1;
        issue(4'h7, 4'd2, 4'd15, 16'h0, 0, 16'h0702, 16'h0077, 16'h0702, 1); // slot 0
        issue(4'h8, 4'd3, 0, 16'h0803, 0, 16'h0003, 16'h0803, 16'h0003, 1);   // slot 1
        issue(4'h9, 4'd4, 0, 16'h0904, 0, 16'h0004, 16'h0904, 16'h0004, 1);   // slot 2
        repeat (2) @(posedge clk);
        log_q.delete();
        @(negedge clk); fu_busy = 1'b0;
        @(posedge clk); #1 fu_busy = 1'b1;
        bcast(4'd15, 16'h0077);
        issue(4'hA, 4'd5, 0, 16'h0A05, 0, 16'h0005, 16'h0A05, 16'h0005, 1);   // reuses slot 1
        @(negedge clk); fu_busy = 1'b0;
        repeat (6) @(posedge clk);
        check(log_q.size() == 4, "R9 dispatch count", log_q.size(), 4);
        if (log_q.size() == 4) begin
          check(log_q[0] == 3, "R9 order pos0", log_q[0], 3);
          check(log_q[1] == 2, "R9 order pos1", log_q[1], 2);
          check(log_q[2] == 4, "R9 order pos2", log_q[2], 4);
          check(log_q[3] == 5, "R9 order pos3", log_q[3], 5);
        end

        // R7: full station rejects issue
        @(negedge clk); fu_busy = 1'b1;
        for (int i = 6; i < 10; i++)
          issue(OP_W'(i), TAG_W'(i), 0, DW'(i), 0, 16'h00F0, DW'(i), 16'h00F0, 1);
        sample();
        check(rs_full == 1, "R7 full with all entries occupied", rs_full, 1);
        issue(4'hE, 4'd10, 0, 16'hEEEE, 0, 16'hEEEE, 0, 0, 0);
        sample();
        check(rs_full == 1, "R7 still full after rejected issue", rs_full, 1);
        log_q.delete();
        @(negedge clk); fu_busy = 1'b0;
        repeat (8) @(posedge clk);
        check(log_q.size() == 4, "R7 rejected issue never dispatched", log_q.size(), 4);
        sample();
        check(rs_full == 0, "R7 full clears after draining", rs_full, 0);

        // R10: every accepted instruction dispatched once
        check(exp_q.size() == 0, "R10 all accepted instructions dispatched", exp_q.size(), 0);
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule